// File: doc/BRIEF.md
# Dual-Channel Serial Wiper Register Controller

This block is the digital core of a two-channel programmable voltage setter. A host talks to it over a three-wire serial link: a clock, a chip-select line and a data input. A data output line is driven only while the chip is selected. Each command opens with a single 1 start bit. It then carries a two-bit channel address and an eight-bit setting, both least-significant bit first. While the data bits are shifting in, the data output shifts back the stored setting of the addressed channel.

Every channel has two kinds of state. One is an eight-bit stored setting, modelled as a register that keeps its value through reset. The other is a volatile working value. A normal command changes only the working value, which lets the host try new settings. The working values are thrown away as soon as chip select falls, and also at power-up reset, so the outputs go back to the stored settings. If the program-enable input is high on the final bit of a command, the setting is also written to storage. A busy period then runs for a set number of serial clock edges. Ready stays low for that period and new commands are ignored.

Top module: `dualset_ctrl`

## Requirements
- R1: While no command is in progress, a 0 on the data input is ignored; a 1 sampled on a rising clock edge with chip select high and ready high starts a command, and the next 10 edges carry A0, A1, then D0..D7.
- R2: On the edge carrying D7 with program-enable low, the addressed channel's output takes the received byte: address 0 drives wiper bits 7:0, address 1 drives wiper bits 15:8; the other channel and the stored settings are unchanged.
- R3: A command whose address has A1=1 (addresses 2 and 3) changes no output and no stored setting and starts no busy period.
- R4: dout_oe equals chip select; during a command to address 0 or 1, dout holds bit i of that channel's stored setting after the (3+i)th edge of the command (the start edge being the first), for i = 0..7, and is 0 at all other times.
- R5: A rising edge with chip select low returns both outputs to their stored settings and abandons any partly received command.
- R6: An output changes only on the final edge of a command addressed to it, on a deselect edge or at reset; reading back a stored setting leaves the outputs untouched.
- R7: The two edges after the final edge of a command are a gap in which a 1 on the data input does not start a command; a start bit on the third edge is accepted.
- R8: If program-enable is high on the final edge of a command to address 0 or 1, the byte goes into both the output and the stored setting of that channel, and ready is low for exactly PROG_CYC following edges.
- R9: While ready is low, no command starts, so a command sent during a busy period leaves every output unchanged.
- R10: Reset makes ready high, leaves no command in progress and shows the stored settings on both outputs; stored settings survive reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; all sampling and shifting on its rising edge |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| cs | input | 1 | Chip select, high enables the serial link |
| din | input | 1 | Serial command data, LSB first after the start bit |
| prog | input | 1 | Program-enable, sampled on the final bit of a command |
| dout | output | 1 | Serial read-back of the addressed stored setting |
| dout_oe | output | 1 | Output enable for dout, low means high impedance |
| ready | output | 1 | High when no storage write is in progress |
| wiper | output | NCH*DW | Active setting of every channel, channel 0 in the low byte |

## Verification
A table of commands is walked in order. It mixes volatile writes, storage writes, writes to the undefined addresses and commands followed by a deselect. These tell apart a change to the working value, a change to storage, an ignored command and a restore. Every command also compares the read-back stream against the bench's own model of storage, so a value that is stored can be told from one that is only shown on the output. Directed cases then cover the following. Ones sent in the two gap edges must not become a start bit, and a start on the third edge must be taken. A command sent during busy must be ignored. A deselect in mid-command must abandon the partial command. A reset must drop working values but keep stored ones.

// File: rtl/dualset_pkg.sv
package dualset_pkg;
   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_ADDR = 2'd1,
      FS_DATA = 2'd2,
      FS_GAP  = 2'd3
   } frm_state_e;
endpackage

// File: rtl/dualset_framer.sv
module dualset_framer #(
   parameter int DW      = 8,
   parameter int AW      = 2,
   parameter int GAP_CYC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_i,
   input  logic          din_i,
   input  logic          busy_i,
   input  logic [DW-1:0] rd_data_i,
   output logic [AW-1:0] rd_sel_o,
   output logic          end_o,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] data_o,
   output logic          dout_o
);
   import dualset_pkg::*;

   localparam int CMAX_A = (DW > GAP_CYC) ? DW : GAP_CYC;
   localparam int CMAX   = (CMAX_A > AW) ? CMAX_A : AW;
   localparam int CW     = $clog2(CMAX + 1);
   localparam frm_state_e AFTER_DATA = (GAP_CYC == 0) ? FS_IDLE : FS_GAP;

   frm_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic [DW-1:0] rd_sh_q;
   logic [AW-1:0] addr_full;
   logic [DW-1:0] data_full;

   assign addr_full = {din_i, addr_q[AW-1:1]};
   assign data_full = {din_i, data_q[DW-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         cnt_q   <= '0;
         addr_q  <= '0;
         data_q  <= '0;
         rd_sh_q <= '0;
      end else if (!cs_i) begin
         state_q <= FS_IDLE;
         cnt_q   <= '0;
         rd_sh_q <= '0;
      end else begin
         unique case (state_q)
            FS_IDLE: begin
               if (din_i && !busy_i) begin
                  state_q <= FS_ADDR;
                  cnt_q   <= '0;
               end
            end
            FS_ADDR: begin
               addr_q <= addr_full;
               if (cnt_q == CW'(AW - 1)) begin
                  state_q <= FS_DATA;
                  cnt_q   <= '0;
                  rd_sh_q <= rd_data_i;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            FS_DATA: begin
               data_q <= data_full;
               if (cnt_q == CW'(DW - 1)) begin
                  state_q <= AFTER_DATA;
                  cnt_q   <= '0;
                  rd_sh_q <= '0;
               end else begin
                  cnt_q   <= cnt_q + CW'(1);
                  rd_sh_q <= rd_sh_q >> 1;
               end
            end
            FS_GAP: begin
               if (cnt_q == CW'(GAP_CYC - 1)) begin
                  state_q <= FS_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   assign rd_sel_o = addr_full;
   assign end_o    = cs_i && (state_q == FS_DATA) && (cnt_q == CW'(DW - 1));
   assign addr_o   = addr_q;
   assign data_o   = data_full;
   assign dout_o   = rd_sh_q[0];

   // R7: a gap edge never opens the address phase
   a_r7_gap_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FS_GAP) |=> (state_q != FS_ADDR));

   // R9: busy keeps the framer idle
   a_r9_busy_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FS_IDLE && busy_i) |=> (state_q == FS_IDLE));

   // R4: no read-back bit outside a command
   a_r4_dout_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FS_IDLE) |-> !dout_o);
endmodule

// File: rtl/dualset_bank.sv
module dualset_bank #(
   parameter int NCH = 2,
   parameter int DW  = 8,
   parameter int AW  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_i,
   input  logic              end_i,
   input  logic              prog_i,
   input  logic [AW-1:0]     addr_i,
   input  logic [DW-1:0]     data_i,
   input  logic [AW-1:0]     rd_sel_i,
   output logic [DW-1:0]     rd_data_o,
   output logic              pgm_o,
   output logic [NCH*DW-1:0] wiper_o
);
   logic [NCH-1:0] sel;
   logic [DW-1:0]  nv_arr [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [DW-1:0] nv_q;
      logic [DW-1:0] vol_q;
      logic          live_q;

      assign sel[c] = end_i && (addr_i == AW'(c));

      // storage copy: deliberately not reset, it survives power cycles
      always_ff @(posedge clk) begin
         if (sel[c] && prog_i) nv_q <= data_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            live_q <= 1'b0;
            vol_q  <= '0;
         end else if (!cs_i) begin
            live_q <= 1'b0;
         end else if (sel[c]) begin
            vol_q  <= data_i;
            live_q <= !prog_i;
         end
      end

      assign nv_arr[c]              = nv_q;
      assign wiper_o[c*DW +: DW]    = live_q ? vol_q : nv_q;

      // R5: a deselect edge shows the stored setting
      a_r5_deselect_restore: assert property (@(posedge clk) disable iff (!rst_n)
         !cs_i |=> (wiper_o[c*DW +: DW] == nv_q));

      // R6: output holds unless its own command ends
      a_r6_hold_unless_addressed: assert property (@(posedge clk) disable iff (!rst_n)
         (cs_i && !sel[c]) |=> $stable(wiper_o[c*DW +: DW]));
   end

   always_comb begin
      rd_data_o = '0;
      for (int c = 0; c < NCH; c++) begin
         if (rd_sel_i == AW'(c)) rd_data_o = nv_arr[c];
      end
   end

   assign pgm_o = prog_i && (|sel);

   // R2: at most one channel is written per command
   a_r2_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
endmodule

// File: rtl/dualset_busy.sv
module dualset_busy #(
   parameter int PROG_CYC = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CW = $clog2(PROG_CYC + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start_i)        cnt_q <= CW'(PROG_CYC);
      else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
   end

   assign busy_o = (cnt_q != '0);

   // R8: a storage write raises busy on the next edge
   a_r8_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o);

   // R8: busy drops only when the count is used up
   a_r8_busy_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> ($past(cnt_q) == CW'(1)));
endmodule

// File: rtl/dualset_ctrl.sv
module dualset_ctrl #(
   parameter int NCH      = 2,
   parameter int DW       = 8,
   parameter int AW       = 2,
   parameter int GAP_CYC  = 2,
   parameter int PROG_CYC = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              din,
   input  logic              prog,
   output logic              dout,
   output logic              dout_oe,
   output logic              ready,
   output logic [NCH*DW-1:0] wiper
);
   initial begin
      assert (NCH >= 1 && NCH <= (1 << AW)) else $error("NCH does not fit AW");
      assert (AW >= 2) else $error("AW must be at least 2");
      assert (DW >= 2) else $error("DW must be at least 2");
      assert (PROG_CYC >= 1) else $error("PROG_CYC must be at least 1");
      assert (GAP_CYC >= 0) else $error("GAP_CYC must not be negative");
   end

   logic          busy;
   logic          frm_end;
   logic [AW-1:0] frm_addr;
   logic [DW-1:0] frm_data;
   logic [AW-1:0] rd_sel;
   logic [DW-1:0] rd_data;
   logic          frm_dout;
   logic          pgm_start;

   dualset_framer #(.DW(DW), .AW(AW), .GAP_CYC(GAP_CYC)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_i      (cs),
      .din_i     (din),
      .busy_i    (busy),
      .rd_data_i (rd_data),
      .rd_sel_o  (rd_sel),
      .end_o     (frm_end),
      .addr_o    (frm_addr),
      .data_o    (frm_data),
      .dout_o    (frm_dout)
   );

   dualset_bank #(.NCH(NCH), .DW(DW), .AW(AW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_i      (cs),
      .end_i     (frm_end),
      .prog_i    (prog),
      .addr_i    (frm_addr),
      .data_i    (frm_data),
      .rd_sel_i  (rd_sel),
      .rd_data_o (rd_data),
      .pgm_o     (pgm_start),
      .wiper_o   (wiper)
   );

   dualset_busy #(.PROG_CYC(PROG_CYC)) u_busy (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (pgm_start),
      .busy_o  (busy)
   );

   assign ready   = !busy;
   assign dout_oe = cs;
   assign dout    = cs & frm_dout;

   // R9: no command completes during a busy period
   a_r9_no_end_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !frm_end);
endmodule

// File: tb/dualset_ctrl_tb.sv
module dualset_ctrl_tb;
   localparam int CLK_P = 10;
   localparam int NCH   = 2;
   localparam int DW    = 8;
   localparam int AW    = 2;
   localparam int PROG  = 24;
   localparam int NVEC  = 10;

   // {addr[1:0], data[7:0], prog, deselect_after}
   localparam logic [11:0] VEC [NVEC] = '{
      {2'd0, 8'hA5, 1'b1, 1'b0},
      {2'd1, 8'h3C, 1'b1, 1'b0},
      {2'd0, 8'hFF, 1'b0, 1'b0},
      {2'd1, 8'h00, 1'b0, 1'b0},
      {2'd2, 8'h77, 1'b0, 1'b0},
      {2'd0, 8'h12, 1'b0, 1'b1},
      {2'd3, 8'hEE, 1'b1, 1'b0},
      {2'd1, 8'h81, 1'b1, 1'b0},
      {2'd0, 8'h00, 1'b1, 1'b0},
      {2'd0, 8'h5A, 1'b0, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0;
   logic din = 1'b0;
   logic prog = 1'b0;
   logic dout, dout_oe, ready;
   logic [NCH*DW-1:0] wiper;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [7:0] m_nv [2];
   logic [7:0] m_wp [2];
   bit known [2] = '{1'b0, 1'b0};

   always #(CLK_P/2) clk = ~clk;

   dualset_ctrl #(.NCH(NCH), .DW(DW), .AW(AW), .GAP_CYC(2), .PROG_CYC(PROG)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .din(din), .prog(prog),
      .dout(dout), .dout_oe(dout_oe), .ready(ready), .wiper(wiper)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_wipers(input string req);
      if (known[0]) chk(req, 32'(wiper[7:0]), 32'(m_wp[0]));
      if (known[1]) chk(req, 32'(wiper[15:8]), 32'(m_wp[1]));
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         din  = 1'b0;
         prog = 1'b0;
      end
   endtask

   // start + A0 A1 + D0..D7; returns at the negedge after the final edge
   task automatic frame(input logic [1:0] a, input logic [7:0] d, input logic p,
                        output logic [7:0] rb, output logic held);
      logic [10:0] bits;
      logic [15:0] snap;
      bits = {d, a, 1'b1};
      rb   = '0;
      held = 1'b1;
      snap = '0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (k == 0) snap = wiper;
         if (k >= 3 && k <= 10) rb[k-3] = dout;
         if (k == 10 && wiper !== snap) held = 1'b0;
         if (k < 11) begin
            din  = bits[k];
            prog = (k == 10) ? p : 1'b0;
         end else begin
            din  = 1'b0;
            prog = 1'b0;
         end
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] rb;
      logic       held;
      int         n;

      repeat (3) @(negedge clk);
      chk("R10 ready after reset", 32'(ready), 32'd1);
      chk("R4 dout_oe low when deselected", 32'(dout_oe), 32'd0);
      chk("R4 dout low when deselected", 32'(dout), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      cs = 1'b1;
      idle(3);
      chk("R4 dout_oe high when selected", 32'(dout_oe), 32'd1);
      chk("R1 dout quiet while idle", 32'(dout), 32'd0);

      for (int i = 0; i < NVEC; i++) begin
         logic [1:0] a;
         logic [7:0] d;
         logic       p, drop, valid, rb_ok;
         logic [7:0] exp_rb;
         {a, d, p, drop} = VEC[i];
         valid  = (a < 2'd2);
         rb_ok  = !valid || known[a[0]];
         exp_rb = (valid && known[a[0]]) ? m_nv[a[0]] : 8'h00;
         frame(a, d, p, rb, held);
         if (rb_ok) chk("R4 read-back of stored setting", 32'(rb), 32'(exp_rb));
         if (known[0] && known[1]) chk("R6 outputs held until final edge", 32'(held), 32'd1);
         if (valid) begin
            m_wp[a[0]] = d;
            if (p) begin
               m_nv[a[0]]  = d;
               known[a[0]] = 1'b1;
            end
         end
         chk_wipers(valid ? "R2/R8 outputs after command" : "R3 undefined address ignored");
         if (valid && p) begin
            chk("R8 ready low after storage write", 32'(ready), 32'd0);
            n = 0;
            while (!ready && n < 1000) begin
               @(negedge clk);
               n++;
            end
            chk("R8 busy length", 32'(n), 32'(PROG));
         end else begin
            chk(valid ? "R2 no busy for volatile write" : "R3 no busy for undefined address",
                32'(ready), 32'd1);
         end
         idle(3);
         if (drop) begin
            @(negedge clk);
            cs = 1'b0;
            @(negedge clk);
            chk("R4 dout_oe follows cs", 32'(dout_oe), 32'd0);
            m_wp[0] = m_nv[0];
            m_wp[1] = m_nv[1];
            chk_wipers("R5 deselect restores stored settings");
            cs = 1'b1;
            idle(3);
         end
      end

      // R1: a run of zeros while idle starts nothing
      idle(6);
      chk_wipers("R1 zeros while idle ignored");

      // R7: ones in the two gap edges are not start bits
      frame(2'd0, 8'h40, 1'b0, rb, held);
      m_wp[0] = 8'h40;
      din = 1'b1;
      @(negedge clk);
      din = 1'b1;
      idle(12);
      chk_wipers("R7 ones in gap ignored");
      frame(2'd1, 8'hD2, 1'b0, rb, held);
      idle(1);
      frame(2'd1, 8'h6E, 1'b0, rb, held);
      m_wp[1] = 8'h6E;
      chk_wipers("R7 start on third edge after command accepted");
      idle(3);

      // R9: commands during busy are dropped
      frame(2'd1, 8'h66, 1'b1, rb, held);
      m_nv[1] = 8'h66;
      m_wp[1] = 8'h66;
      idle(1);
      frame(2'd1, 8'h99, 1'b0, rb, held);
      chk("R9 still busy", 32'(ready), 32'd0);
      chk_wipers("R9 command during busy ignored");
      n = 0;
      while (!ready && n < 1000) begin
         @(negedge clk);
         n++;
      end
      idle(3);
      chk_wipers("R9 outputs after busy period");

      // R5: deselect mid-command abandons it
      frame(2'd0, 8'hC3, 1'b0, rb, held);
      m_wp[0] = 8'hC3;
      idle(3);
      chk_wipers("R2 volatile write before abort");
      @(negedge clk); din = 1'b1;
      @(negedge clk); din = 1'b1;
      @(negedge clk); din = 1'b0;
      @(negedge clk); din = 1'b1;
      @(negedge clk); din = 1'b1;
      @(negedge clk); cs = 1'b0; din = 1'b0;
      @(negedge clk);
      m_wp[0] = m_nv[0];
      m_wp[1] = m_nv[1];
      chk_wipers("R5 restore on mid-command deselect");
      cs = 1'b1;
      idle(3);
      chk_wipers("R5 partial command dropped");
      frame(2'd0, 8'h2B, 1'b0, rb, held);
      m_wp[0] = 8'h2B;
      chk_wipers("R5 fresh command after abort");
      idle(3);

      // R10: reset drops working values, keeps storage
      frame(2'd1, 8'h17, 1'b0, rb, held);
      m_wp[1] = 8'h17;
      chk_wipers("R2 volatile write before reset");
      idle(2);
      rst_n = 1'b0;
      @(negedge clk);
      m_wp[0] = m_nv[0];
      m_wp[1] = m_nv[1];
      chk_wipers("R10 reset shows stored settings");
      chk("R10 ready high in reset", 32'(ready), 32'd1);
      rst_n = 1'b1;
      idle(3);
      frame(2'd1, 8'h00, 1'b0, rb, held);
      chk("R10 storage kept through reset", 32'(rb), 32'(m_nv[1]));
      m_wp[1] = 8'h00;
      chk_wipers("R2 write after reset");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule